// File: doc/BRIEF.md
# Synthesizer Tuning Control Receiver (I2C write-only slave)

This block receives tuning commands for a frequency synthesizer over a two-wire I2C bus. It only receives. It finds start and stop conditions and shifts in each byte on rising SCL. When a byte is accepted, it pulls SDA low during the ninth clock. A telegram belongs to this block only when its first byte carries the 7-bit chip address `1100_0` followed by the two-bit strap value, and its eighth bit is 0 (write).

After the address, the data bytes are read as consecutive pairs. The most significant bit of the first byte of each pair picks what the pair loads:

- When that bit is 0, the pair loads a 15-bit divider ratio.
- When that bit is 1, the pair loads the loop-control flags and the port outputs.

A pair writes its register only when its second byte has been received and acknowledged. A start or stop that interrupts a byte drops the pair in progress and leaves every register as it was.

SCL and SDA are sampled by a system clock through two-flop synchronizers. That clock must run at least 8 times the SCL rate. The register outputs drive the synthesizer's divider, the charge pump and the band-switch pins directly.

Top module: `tuner_i2c_ctl`

## Requirements
- R1: After reset the divider ratio is 256, every control flag and port output is 0, and SDA is not pulled.
- R2: A first byte equal to {5'b11000, addr_sel, 1'b0} is acknowledged. The block pulls SDA low from the falling edge of SCL after bit 8 until the falling edge of the ninth clock.
- R3: A first byte with any other address, or with the eighth bit set to 1 (read), is not acknowledged. The data bytes after it, up to the next start, are neither acknowledged nor able to change any register.
- R4: In an addressed telegram, every data byte is acknowledged on its ninth clock.
- R5: A pair whose first byte has bit 7 = 0 sets the divider ratio to {first[6:0], second[7:0]}. The boundary values 256 and 32767 load exactly.
- R6: A pair whose first byte has bit 7 = 1 loads the control flags and ports. From the first byte: bit 6 sets pump_hi, bit 5 sets test_route, bit 4 sets cp_hiz, and bit 3 sets tune_off. From the second byte: bit 0 sets port1, bit 1 sets port2, and bit 7 sets port7. All other bits are ignored.
- R7: Data bytes alternate between first-of-pair and second-of-pair. The third data byte therefore starts a new pair, and a four-byte telegram can load both registers in either order.
- R8: A register changes only once the second byte of its pair is acknowledged. A telegram that ends after the first byte of a pair leaves all outputs unchanged.
- R9: A stop or a start in the middle of a byte aborts the pair in progress without changing any register and releases SDA. The next telegram is decoded normally.
- R10: A repeated start inside a telegram returns the block to the address phase, and the address byte after it is matched again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | I2C clock line as seen on the bus |
| sda_in | input | 1 | I2C data line as seen on the bus |
| addr_sel | input | 2 | Strap that sets the two low chip-address bits |
| sda_pull | output | 1 | 1 pulls SDA low (acknowledge) |
| div_ratio | output | 15 | Divider ratio for the synthesizer |
| cp_hiz | output | 1 | Charge pump forced to high impedance |
| test_route | output | 1 | Route divided input to port7 test path |
| pump_hi | output | 1 | Select the high pump current |
| tune_off | output | 1 | Switch off the tuning-voltage output |
| port1 | output | 1 | Band-switch output 1 |
| port2 | output | 1 | Band-switch output 2 |
| port7 | output | 1 | General-purpose output |

## Verification
The bench targets the places where pair tracking can go wrong:

- **Lone first byte.** A telegram that stops after one byte checks for a register being written early.
- **Three-byte telegram.** It catches a pair counter that fails to restart at the third byte.
- **Interrupted byte.** A stop or repeated start in the middle of a byte checks for a partial byte being committed, or for SDA staying pulled.
- **Non-matching first byte.** Wrong addresses and read bits check for a block that acknowledges or loads data it does not own.

Random telegrams with mixed pair kinds and strap values check that bits land in the wrong field nowhere. The divider boundaries 256 and 32767 are covered as directed cases.

// File: rtl/tuner_i2c_pkg.sv
package tuner_i2c_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } bus_state_e;

    typedef struct packed {
        bus_state_e        state;
        logic [3:0]        bits;
        logic [BYTE_W-1:0] shift;
        logic              ack;
        logic              scl_p;
        logic              sda_p;
    } bus_reg_t;

    typedef struct packed {
        logic pump_hi;
        logic test_route;
        logic cp_hiz;
        logic tune_off;
        logic port7;
        logic port2;
        logic port1;
    } ctrl_t;

endpackage

// File: rtl/tic_sync.sv
module tic_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
        end else begin
            stage_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/tic_bus.sv
module tic_bus
    import tuner_i2c_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic [ADDR_W-1:0] dev_addr,
    output logic              ack_pull,
    output logic              byte_stb,
    output logic [BYTE_W-1:0] byte_data,
    output logic              bus_evt
);
    localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

    bus_reg_t r_q, r_d;
    logic rise, fall, start_c, stop_c;

    always_comb begin
        r_d      = r_q;
        byte_stb = 1'b0;
        bus_evt  = 1'b0;
        r_d.scl_p = scl_s;
        r_d.sda_p = sda_s;
        rise    = scl_s & ~r_q.scl_p;
        fall    = ~scl_s & r_q.scl_p;
        start_c = scl_s & r_q.scl_p & r_q.sda_p & ~sda_s;
        stop_c  = scl_s & r_q.scl_p & ~r_q.sda_p & sda_s;
        if (start_c) begin
            r_d.state = ST_ADDR;
            r_d.bits  = '0;
            r_d.ack   = 1'b0;
            bus_evt   = 1'b1;
        end else if (stop_c) begin
            r_d.state = ST_IDLE;
            r_d.bits  = '0;
            r_d.ack   = 1'b0;
            bus_evt   = 1'b1;
        end else begin
            case (r_q.state)
                ST_ADDR, ST_DATA: begin
                    if (rise && r_q.bits < LAST_BIT) begin
                        r_d.shift = {r_q.shift[BYTE_W-2:0], sda_s};
                        r_d.bits  = r_q.bits + 4'd1;
                    end
                    if (fall && r_q.bits == LAST_BIT) begin
                        if (r_q.state == ST_DATA) begin
                            r_d.ack   = 1'b1;
                            r_d.state = ST_DATA_ACK;
                        end else if (r_q.shift == {dev_addr, 1'b0}) begin
                            r_d.ack   = 1'b1;
                            r_d.state = ST_ADDR_ACK;
                        end else begin
                            r_d.state = ST_SKIP;
                        end
                    end
                end
                ST_ADDR_ACK, ST_DATA_ACK: begin
                    if (fall) begin
                        r_d.ack   = 1'b0;
                        r_d.bits  = '0;
                        r_d.state = ST_DATA;
                        byte_stb  = (r_q.state == ST_DATA_ACK);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.scl_p <= 1'b1;
            r_q.sda_p <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign ack_pull  = r_q.ack;
    assign byte_data = r_q.shift;

    assert_ack_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.ack) |-> !scl_s);
    assert_skip_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_SKIP) |-> !r_q.ack);
    assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> !r_q.ack);
endmodule

// File: rtl/tic_regs.sv
module tic_regs
    import tuner_i2c_pkg::*;
#(
    parameter int          DIV_W     = 15,
    parameter logic [14:0] DIV_RESET = 15'd256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_stb,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              bus_evt,
    output logic [DIV_W-1:0]  div_ratio,
    output ctrl_t             ctrl
);
    localparam int HI_W = DIV_W - BYTE_W;

    typedef struct packed {
        logic              have;
        logic [BYTE_W-1:0] first;
        logic [DIV_W-1:0]  div;
        ctrl_t             ctrl;
    } regs_t;

    regs_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (bus_evt) begin
            s_d.have = 1'b0;
        end else if (byte_stb) begin
            if (!s_q.have) begin
                s_d.have  = 1'b1;
                s_d.first = byte_data;
            end else begin
                s_d.have = 1'b0;
                if (!s_q.first[BYTE_W-1]) begin
                    s_d.div = {s_q.first[HI_W-1:0], byte_data};
                end else begin
                    s_d.ctrl.pump_hi    = s_q.first[6];
                    s_d.ctrl.test_route = s_q.first[5];
                    s_d.ctrl.cp_hiz     = s_q.first[4];
                    s_d.ctrl.tune_off   = s_q.first[3];
                    s_d.ctrl.port7      = byte_data[7];
                    s_d.ctrl.port2      = byte_data[1];
                    s_d.ctrl.port1      = byte_data[0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.div <= DIV_RESET[DIV_W-1:0];
        end else begin
            s_q <= s_d;
        end
    end

    assign div_ratio = s_q.div;
    assign ctrl      = s_q.ctrl;

    assert_div_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.div) |-> $past(byte_stb));
    assert_ctrl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.ctrl) |-> $past(byte_stb));
endmodule

// File: rtl/tuner_i2c_ctl.sv
module tuner_i2c_ctl
    import tuner_i2c_pkg::*;
#(
    parameter int         DIV_W     = 15,
    parameter int         SYNC_N    = 2,
    parameter logic [4:0] ADDR_BASE = 5'b11000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic [1:0]       addr_sel,
    output logic             sda_pull,
    output logic [DIV_W-1:0] div_ratio,
    output logic             cp_hiz,
    output logic             test_route,
    output logic             pump_hi,
    output logic             tune_off,
    output logic             port1,
    output logic             port2,
    output logic             port7
);
    localparam int ADDR_W = 7;

    logic [1:0]        lines_s;
    logic              byte_stb, bus_evt;
    logic [BYTE_W-1:0] byte_data;
    ctrl_t             ctrl;

    tic_sync #(.WIDTH(2), .STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_in({scl_in, sda_in}), .sync_out(lines_s)
    );

    tic_bus #(.ADDR_W(ADDR_W)) u_bus (
        .clk(clk), .rst_n(rst_n),
        .scl_s(lines_s[1]), .sda_s(lines_s[0]),
        .dev_addr({ADDR_BASE, addr_sel}),
        .ack_pull(sda_pull), .byte_stb(byte_stb),
        .byte_data(byte_data), .bus_evt(bus_evt)
    );

    tic_regs #(.DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .byte_stb(byte_stb), .byte_data(byte_data), .bus_evt(bus_evt),
        .div_ratio(div_ratio), .ctrl(ctrl)
    );

    assign cp_hiz     = ctrl.cp_hiz;
    assign test_route = ctrl.test_route;
    assign pump_hi    = ctrl.pump_hi;
    assign tune_off   = ctrl.tune_off;
    assign port1      = ctrl.port1;
    assign port2      = ctrl.port2;
    assign port7      = ctrl.port7;

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !sda_pull);
endmodule

// File: tb/tuner_i2c_ctl_bench.sv
module tuner_i2c_ctl_bench;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic [1:0] addr_sel = 2'd0;
    logic sda_pull, cp_hiz, test_route, pump_hi, tune_off, port1, port2, port7;
    logic [14:0] div_ratio;
    wire sda_bus = m_sda & ~sda_pull;

    int checks = 0, fails = 0;
    logic [14:0] exp_div;
    logic [6:0]  exp_ctrl;
    logic [7:0]  tx [4];

    always #4 clk = ~clk;

    tuner_i2c_ctl u_tuner_i2c_ctl (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
        .addr_sel(addr_sel), .sda_pull(sda_pull), .div_ratio(div_ratio),
        .cp_hiz(cp_hiz), .test_route(test_route), .pump_hi(pump_hi),
        .tune_off(tune_off), .port1(port1), .port2(port2), .port7(port7)
    );

    function automatic logic [6:0] ctrl_now();
        return {pump_hi, test_route, cp_hiz, tune_off, port7, port2, port1};
    endfunction

    function automatic logic [6:0] ctrl_of(logic [7:0] a, logic [7:0] b);
        return {a[6], a[5], a[4], a[3], b[7], b[1], b[0]};
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_q(int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic do_start();
        m_sda = 1'b1; wait_q(1);
        m_scl = 1'b1; wait_q(1);
        m_sda = 1'b0; wait_q(1);
        m_scl = 1'b0; wait_q(1);
    endtask

    task automatic do_stop();
        m_sda = 1'b0; wait_q(1);
        m_scl = 1'b1; wait_q(1);
        m_sda = 1'b1; wait_q(2);
    endtask

    task automatic send_bit(logic b);
        m_sda = b; wait_q(1);
        m_scl = 1'b1; wait_q(2);
        m_scl = 1'b0; wait_q(1);
    endtask

    task automatic send_byte(logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1; wait_q(1);
        m_scl = 1'b1; wait_q(1);
        acked = ~sda_bus;
        wait_q(1);
        m_scl = 1'b0; wait_q(1);
    endtask

    task automatic check_regs(string req);
        check(div_ratio == exp_div, req, 32'(div_ratio), 32'(exp_div));
        check(ctrl_now() == exp_ctrl, req, 32'(ctrl_now()), 32'(exp_ctrl));
        check(sda_pull == 1'b0, req, 32'(sda_pull), 0);
    endtask

    // full telegram: address byte then n data bytes from tx, model updated
    task automatic telegram(logic [6:0] addr, logic rw, int n, string req);
        logic acked, match;
        match = (addr == {5'b11000, addr_sel}) && !rw;
        do_start();
        send_byte({addr, rw}, acked);
        check(acked == match, match ? "R2" : "R3", 32'(acked), 32'(match));
        for (int i = 0; i < n; i++) begin
            send_byte(tx[i], acked);
            check(acked == match, match ? "R4" : "R3", 32'(acked), 32'(match));
            if (match && i % 2 == 1) begin
                if (!tx[i-1][7]) exp_div = {tx[i-1][6:0], tx[i]};
                else exp_ctrl = ctrl_of(tx[i-1], tx[i]);
            end
        end
        do_stop();
        wait_q(1);
        check_regs(req);
    endtask

    initial begin
        logic acked;
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        exp_div = 15'd256;
        exp_ctrl = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check_regs("R1");

        // R5 divider boundaries
        tx[0] = 8'h01; tx[1] = 8'h00;
        telegram(7'b1100000, 1'b0, 2, "R5");
        tx[0] = 8'h7F; tx[1] = 8'hFF;
        telegram(7'b1100000, 1'b0, 2, "R5");

        // R6 control bits, other bits set to prove they are ignored
        addr_sel = 2'd3;
        tx[0] = 8'hC7; tx[1] = 8'h7D;
        telegram(7'b1100011, 1'b0, 2, "R6");
        tx[0] = 8'hB8; tx[1] = 8'h82;
        telegram(7'b1100011, 1'b0, 2, "R6");

        // R7 four bytes, control then divider; three bytes
        addr_sel = 2'd1;
        tx[0] = 8'hF8; tx[1] = 8'h83; tx[2] = 8'h12; tx[3] = 8'h34;
        telegram(7'b1100001, 1'b0, 4, "R7");
        tx[0] = 8'h05; tx[1] = 8'h55; tx[2] = 8'h80;
        telegram(7'b1100001, 1'b0, 3, "R7");

        // R8 lone first byte
        tx[0] = 8'h20;
        telegram(7'b1100001, 1'b0, 1, "R8");

        // R3 wrong address and read bit
        tx[0] = 8'h33; tx[1] = 8'h33;
        telegram(7'b1100010, 1'b0, 2, "R3");
        telegram(7'b1100001, 1'b1, 2, "R3");

        // R9 stop mid-byte
        do_start();
        send_byte(8'hC2, acked);
        send_byte(8'h11, acked);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        do_stop();
        wait_q(1);
        check_regs("R9");

        // R10 / R9 repeated start mid-byte, then a new addressed telegram
        do_start();
        send_byte(8'hC2, acked);
        send_byte(8'h22, acked);
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        do_start();
        send_byte(8'hC2, acked);
        check(acked == 1'b1, "R10", 32'(acked), 1);
        send_byte(8'h03, acked);
        send_byte(8'h21, acked);
        exp_div = 15'h0321;
        do_stop();
        wait_q(1);
        check_regs("R10");

        // random telegrams
        for (int t = 0; t < 30; t++) begin
            logic [6:0] a;
            logic rw;
            int n;
            addr_sel = 2'($urandom);
            a = {5'b11000, addr_sel};
            if ($urandom % 5 == 0) a = a ^ 7'(1 << ($urandom % 7));
            rw = ($urandom % 8 == 0);
            n = 1 + int'($urandom % 4);
            for (int i = 0; i < 4; i++) tx[i] = 8'($urandom);
            telegram(a, rw, n, "R7");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule